// File: doc/BRIEF.md
# In-Place Compute SRAM Sub-Array

This block is a cycle-level model of one SRAM sub-array that can compute where its data sits. It holds a small number of rows, and each row is one 512-bit cache block made of eight 64-bit words. Besides plain single-row reads and writes, it can activate two rows together. Each column is then sensed twice. The true line gives the AND of the two stored bits. The complement line gives their NOR. Every compound operation is built from those two senses. OR is the inverse of the NOR sense. XOR is the NOR of the two senses. NOT and copy use a single activated row. Copy writes the sensed value back into the destination without holding the source in a latch. Zeroing clears the write-data latch and then writes it.

A result either goes into a destination row or comes back on a 64-bit result port. A word compare gives one equality bit per word. A key search compares every word of every row against a key row, which gives 8 rows × 8 words = 64 match bits. A carryless-multiply step ANDs two rows and reduces each 64-, 128- or 256-bit chunk to one parity bit. Each command is taken through a valid/busy/done handshake. The latency is fixed by the operation class, counted in multiples of a single access time `ACC`.

The controller is a three-state machine:
- **IDLE**: waits for a command. It leaves on **ACCEPT**, which needs a valid, known opcode.
- **ACTIVE**: counts the operation's latency. It leaves on **EXPIRE** when the count reaches zero. Any row update and any output register update happen on that edge.
- **DONE**: lasts one cycle with `done` high. It then takes **RETIRE** back to IDLE.

Top module: `blc_subarray`

## Requirements
- R1: A WRITE (opcode 1) stores `cmd_wdata` into row `cmd_rd`. A READ (opcode 0) of row `cmd_ra` places that row on `rdata` in the DONE cycle. `rdata` holds that value until the next READ completes.
- R2: AND (opcode 4) writes `row[ra] & row[rb]` into row `rd`. It takes 3×ACC ACTIVE cycles. READ, WRITE take ACC cycles.
- R3: OR (opcode 5) writes `row[ra] | row[rb]` into row `rd`, in 3×ACC ACTIVE cycles.
- R4: XOR (opcode 6) writes `row[ra] ^ row[rb]` into row `rd`, in 3×ACC ACTIVE cycles.
- R5: NOT (opcode 7) writes `~row[ra]` into row `rd`, in 2×ACC ACTIVE cycles.
- R6: COPY (opcode 2) writes `row[ra]` into row `rd` and leaves the source row unchanged, in 2×ACC ACTIVE cycles.
- R7: ZERO (opcode 3) writes all zeros into row `rd`, whatever `cmd_wdata` holds, in 2×ACC ACTIVE cycles.
- R8: COMPARE (opcode 8) sets `result[w]` to 1 exactly when word w (bits `[64w+63:64w]`) of `row[ra]` equals word w of `row[rb]`, for w = 0..7. Bits 63:8 of `result` are 0. It takes 2×ACC ACTIVE cycles.
- R9: SEARCH (opcode 9) sets `result[8r+w]` to 1 exactly when word w of row r equals word w of key row `rb`, for every row r and word w. It takes 2×ACC ACTIVE cycles.
- R10: CLMUL (opcode 10) sets `result[c]` to the XOR of all bits of chunk c of `row[ra] & row[rb]`. The chunk size is 64, 128 or 256 bits for `cmd_gran` = 0, 1 or 2, and 256 bits for `cmd_gran` = 3. All higher result bits are 0 and no row changes. It takes 2×ACC ACTIVE cycles.
- R11: From the edge that accepts a command, `busy` is high for LAT+1 cycles, where LAT is the class latency. `done` is high only in the last of those cycles. No row changes before the edge that starts that `done` cycle.
- R12: A command presented while `busy` is high, or one with an opcode from 11 to 15, is ignored. It changes neither the rows, nor `busy`, nor the outputs.
- R13: After reset, `busy`, `done`, `rdata` and `result` are 0 and every row reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Opcode (0 READ … 10 CLMUL) |
| cmd_ra | input | 3 | First source row |
| cmd_rb | input | 3 | Second source row / key row |
| cmd_rd | input | 3 | Destination row |
| cmd_gran | input | 2 | CLMUL chunk size select |
| cmd_wdata | input | 512 | Write data for WRITE |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 512 | Last row read |
| result | output | 64 | Last compare/search/CLMUL result |

## Verification
The reference model in the bench works out `busy` and `done` itself for every clock. A state machine that leaves ACTIVE early or late, or that takes a command while busy, therefore shows up as a mismatch in the very cycle it goes wrong. A wrong sense equation, a swapped row address, or an early or stray row write does not show straight away. It stays inside the array until a later READ brings that row to `rdata`, at the end of that READ's latency. For that reason every computed row is read back and tagged with the operation that wrote it. Faults in the compare, search and parity paths show on `result` in the DONE cycle of the command that caused them.

// File: rtl/blc_pkg.sv
package blc_pkg;

    typedef enum logic [3:0] {
        OP_READ   = 4'd0,
        OP_WRITE  = 4'd1,
        OP_COPY   = 4'd2,
        OP_ZERO   = 4'd3,
        OP_AND    = 4'd4,
        OP_OR     = 4'd5,
        OP_XOR    = 4'd6,
        OP_NOT    = 4'd7,
        OP_CMP    = 4'd8,
        OP_SEARCH = 4'd9,
        OP_CLMUL  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } state_e;

    function automatic logic op_known(input logic [3:0] op);
        return op <= 4'd10;
    endfunction

    // latency in multiples of one single-row access
    function automatic int op_mult(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return 1;
            4'd4, 4'd5, 4'd6: return 3;
            default:          return 2;
        endcase
    endfunction

    function automatic logic op_dual(input op_e op);
        return !(op == OP_READ || op == OP_COPY || op == OP_NOT);
    endfunction

endpackage

// File: rtl/blc_sense.sv
module blc_sense #(
    parameter int BW = 512
) (
    input  logic [BW-1:0] row_a,
    input  logic [BW-1:0] row_b,
    input  logic          dual,
    output logic [BW-1:0] bl_t,
    output logic [BW-1:0] bl_c
);
    // per column: precharged true and complement lines, pulled low by any active 0 / 1
    for (genvar i = 0; i < BW; i++) begin : g_col
        always_comb begin
            if (dual) begin
                bl_t[i] = row_a[i] & row_b[i];
                bl_c[i] = ~row_a[i] & ~row_b[i];
            end else begin
                bl_t[i] = row_a[i];
                bl_c[i] = ~row_a[i];
            end
        end
    end
endmodule

// File: rtl/blc_word_eq.sv
module blc_word_eq #(
    parameter int BW = 512,
    parameter int WB = 64,
    localparam int NW = BW / WB
) (
    input  logic [BW-1:0] diff,
    output logic [NW-1:0] eq
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        assign eq[w] = ~|diff[w*WB +: WB];
    end
endmodule

// File: rtl/blc_xor_tree.sv
module blc_xor_tree #(
    parameter int BW    = 512,
    parameter int RES_W = 64
) (
    input  logic [BW-1:0]    prod,
    input  logic [1:0]       gran,
    output logic [RES_W-1:0] par
);
    localparam int N64  = BW / 64;
    localparam int N128 = BW / 128;
    localparam int N256 = BW / 256;

    logic [N64-1:0]  p64;
    logic [N128-1:0] p128;
    logic [N256-1:0] p256;

    for (genvar c = 0; c < N64; c++) begin : g_c64
        assign p64[c] = ^prod[c*64 +: 64];
    end
    for (genvar c = 0; c < N128; c++) begin : g_c128
        assign p128[c] = ^prod[c*128 +: 128];
    end
    for (genvar c = 0; c < N256; c++) begin : g_c256
        assign p256[c] = ^prod[c*256 +: 256];
    end

    always_comb begin
        par = '0;
        case (gran)
            2'd0:    par[N64-1:0]  = p64;
            2'd1:    par[N128-1:0] = p128;
            default: par[N256-1:0] = p256;
        endcase
    end
endmodule

// File: rtl/blc_ctrl.sv
module blc_ctrl
    import blc_pkg::*;
#(
    parameter int ACC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    output logic       accept,
    output logic       commit,
    output logic       busy,
    output logic       done
);
    localparam int MAXL = 3 * ACC;
    localparam int CW   = $clog2(MAXL + 1);

    state_e         st_q, st_d;
    logic [CW-1:0]  cnt_q;

    assign accept = cmd_valid && (st_q == ST_IDLE) && op_known(cmd_op);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = accept ? ST_ACTIVE : ST_IDLE;       // ACCEPT
            ST_ACTIVE: st_d = (cnt_q == '0) ? ST_DONE : ST_ACTIVE; // EXPIRE
            ST_DONE:   st_d = ST_IDLE;                            // RETIRE
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept)
                cnt_q <= CW'(ACC * op_mult(cmd_op) - 1);
            else if (st_q == ST_ACTIVE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy   = (st_q != ST_IDLE);
        done   = (st_q == ST_DONE);
        commit = (st_q == ST_ACTIVE) && (cnt_q == '0);
    end

    // independent elapsed-cycle counter for the latency check
    logic [CW-1:0] chk_el_q, chk_lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_el_q  <= '0;
            chk_lat_q <= '0;
        end else if (accept) begin
            chk_el_q  <= '0;
            chk_lat_q <= CW'(ACC * op_mult(cmd_op));
        end else if (st_q == ST_ACTIVE) begin
            chk_el_q <= chk_el_q + 1'b1;
        end
    end

    assert_done_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_el_q == chk_lat_q));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/blc_subarray.sv
module blc_subarray
    import blc_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int BW    = 512,
    parameter int WB    = 64,
    parameter int RES_W = 64,
    parameter int ACC   = 2,
    localparam int RW    = $clog2(ROWS),
    localparam int WORDS = BW / WB,
    localparam int SRCH_W = ROWS * WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [RW-1:0]    cmd_ra,
    input  logic [RW-1:0]    cmd_rb,
    input  logic [RW-1:0]    cmd_rd,
    input  logic [1:0]       cmd_gran,
    input  logic [BW-1:0]    cmd_wdata,
    output logic             busy,
    output logic             done,
    output logic [BW-1:0]    rdata,
    output logic [RES_W-1:0] result
);
    logic accept, commit;

    blc_ctrl #(.ACC(ACC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .accept(accept), .commit(commit), .busy(busy), .done(done)
    );

    // command registers and the write-data latch
    op_e            op_q;
    logic [RW-1:0]  ra_q, rb_q, rd_q;
    logic [1:0]     gran_q;
    logic [BW-1:0]  wlatch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_READ;
            ra_q     <= '0;
            rb_q     <= '0;
            rd_q     <= '0;
            gran_q   <= '0;
            wlatch_q <= '0;
        end else if (accept) begin
            op_q   <= op_e'(cmd_op);
            ra_q   <= cmd_ra;
            rb_q   <= cmd_rb;
            rd_q   <= cmd_rd;
            gran_q <= cmd_gran;
            if (op_e'(cmd_op) == OP_ZERO)
                wlatch_q <= '0;
            else if (op_e'(cmd_op) == OP_WRITE)
                wlatch_q <= cmd_wdata;
        end
    end

    logic [BW-1:0] mem_q [ROWS];

    // two-row activation for logic, compare and clmul
    logic [BW-1:0] ab_t, ab_c, ab_x;
    blc_sense #(.BW(BW)) u_sense_ab (
        .row_a(mem_q[ra_q]), .row_b(mem_q[rb_q]), .dual(op_dual(op_q)),
        .bl_t(ab_t), .bl_c(ab_c)
    );
    assign ab_x = ~(ab_t | ab_c);

    logic [WORDS-1:0] cmp_eq;
    blc_word_eq #(.BW(BW), .WB(WB)) u_cmp (.diff(ab_x), .eq(cmp_eq));

    logic [RES_W-1:0] clm_par;
    blc_xor_tree #(.BW(BW), .RES_W(RES_W)) u_clm (
        .prod(ab_t), .gran(gran_q), .par(clm_par)
    );

    // key search: every row activated against the key row
    logic [SRCH_W-1:0] srch_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_srch
        logic [BW-1:0] s_t, s_c;
        blc_sense #(.BW(BW)) u_sense_k (
            .row_a(mem_q[r]), .row_b(mem_q[rb_q]), .dual(1'b1),
            .bl_t(s_t), .bl_c(s_c)
        );
        blc_word_eq #(.BW(BW), .WB(WB)) u_eq (
            .diff(~(s_t | s_c)), .eq(srch_bits[r*WORDS +: WORDS])
        );
    end

    // row write-back selection
    logic          wr_en;
    logic [RW-1:0] wr_row;
    logic [BW-1:0] wr_data;

    always_comb begin
        wr_en   = 1'b0;
        wr_row  = rd_q;
        wr_data = '0;
        unique case (op_q)
            OP_WRITE, OP_ZERO: begin wr_en = commit; wr_data = wlatch_q; end
            OP_COPY:           begin wr_en = commit; wr_data = ab_t;     end
            OP_AND:            begin wr_en = commit; wr_data = ab_t;     end
            OP_OR:             begin wr_en = commit; wr_data = ~ab_c;    end
            OP_XOR:            begin wr_en = commit; wr_data = ab_x;     end
            OP_NOT:            begin wr_en = commit; wr_data = ab_c;     end
            default:           wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end
    end

    // output registers, updated only when a command completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            result <= '0;
        end else if (commit) begin
            case (op_q)
                OP_READ:   rdata  <= ab_t;
                OP_CMP:    result <= RES_W'(cmp_eq);
                OP_SEARCH: result <= RES_W'(srch_bits);
                OP_CLMUL:  result <= clm_par;
                default:   ;
            endcase
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        assert_row_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_row == RW'(r)) |=> $stable(mem_q[r]));
    end

    if (WORDS < RES_W) begin : g_cmp_chk
        assert_cmp_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done && op_q == OP_CMP) |-> (result[RES_W-1:WORDS] == '0));
    end

    assert_commit_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy && !done));
endmodule

// File: tb/sim_blc_subarray.sv
`timescale 1ns/1ps
module sim_blc_subarray;
    localparam int ACC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_op = '0;
    logic [2:0]   cmd_ra = '0, cmd_rb = '0, cmd_rd = '0;
    logic [1:0]   cmd_gran = '0;
    logic [511:0] cmd_wdata = '0;
    logic         busy, done;
    logic [511:0] rdata;
    logic [63:0]  result;

    always #2.5 clk = ~clk;

    blc_subarray u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_rd(cmd_rd), .cmd_gran(cmd_gran),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rdata(rdata), .result(result)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // ---------------- reference model ----------------
    logic [511:0] m_mem [8];
    string        m_tag [8];
    logic [511:0] m_rdata;
    logic [63:0]  m_res;
    string        m_rd_tag, m_res_tag;
    int           m_rem;
    int           p_op, p_ra, p_rb, p_rd, p_g;
    logic [511:0] p_wd;

    function automatic int lat_of(int op);
        if (op <= 1) return ACC;
        if (op >= 4 && op <= 6) return 3 * ACC;
        return 2 * ACC;
    endfunction

    task automatic model_apply();
        logic [511:0] a, b, p;
        int sz;
        a = m_mem[p_ra];
        b = m_mem[p_rb];
        case (p_op)
            0: begin m_rdata = a; m_rd_tag = m_tag[p_ra]; end
            1: begin m_mem[p_rd] = p_wd; m_tag[p_rd] = "R1"; end
            2: begin m_mem[p_rd] = a; m_tag[p_rd] = "R6"; end
            3: begin m_mem[p_rd] = '0; m_tag[p_rd] = "R7"; end
            4: begin m_mem[p_rd] = a & b; m_tag[p_rd] = "R2"; end
            5: begin m_mem[p_rd] = a | b; m_tag[p_rd] = "R3"; end
            6: begin m_mem[p_rd] = a ^ b; m_tag[p_rd] = "R4"; end
            7: begin m_mem[p_rd] = ~a; m_tag[p_rd] = "R5"; end
            8: begin
                m_res = '0;
                for (int w = 0; w < 8; w++) m_res[w] = (a[w*64 +: 64] == b[w*64 +: 64]);
                m_res_tag = "R8";
            end
            9: begin
                m_res = '0;
                for (int r = 0; r < 8; r++)
                    for (int w = 0; w < 8; w++)
                        m_res[r*8+w] = (m_mem[r][w*64 +: 64] == b[w*64 +: 64]);
                m_res_tag = "R9";
            end
            10: begin
                p = a & b;
                sz = (p_g == 0) ? 64 : (p_g == 1) ? 128 : 256;
                m_res = '0;
                for (int i = 0; i < 512; i++) m_res[i / sz] = m_res[i / sz] ^ p[i];
                m_res_tag = "R10";
            end
            default: ;
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin m_mem[r] = '0; m_tag[r] = "R13"; end
            m_rdata = '0; m_res = '0; m_rem = 0;
            m_rd_tag = "R13"; m_res_tag = "R13";
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
            if (m_rem == 1) model_apply();
        end else if (cmd_valid && cmd_op <= 4'd10) begin
            p_op = int'(cmd_op); p_ra = int'(cmd_ra); p_rb = int'(cmd_rb);
            p_rd = int'(cmd_rd); p_g = int'(cmd_gran); p_wd = cmd_wdata;
            m_rem = lat_of(p_op) + 1;
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic fail_line(string tag, string what, logic [511:0] act, logic [511:0] exp);
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp++;
            if (busy !== (m_rem > 0) || done !== (m_rem == 1))
                fail_line("R11", "busy/done", {510'd0, busy, done},
                          {510'd0, (m_rem > 0), (m_rem == 1)});
            else if (rdata !== m_rdata)
                fail_line(m_rd_tag, "rdata", rdata, m_rdata);
            else if (result !== m_res)
                fail_line(m_res_tag, "result", {448'd0, result}, {448'd0, m_res});
        end
    end

    task automatic chk(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
        n_cmp++;
        if (!ok) fail_line(tag, "check", act, exp);
    endtask

    // ---------------- stimulus ----------------
    task automatic issue(int op, int ra, int rb, int rd, int g, logic [511:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_ra = 3'(ra); cmd_rb = 3'(rb);
        cmd_rd = 3'(rd); cmd_gran = 2'(g); cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (m_rem > 0) @(negedge clk);
    endtask

    function automatic logic [511:0] pat(int s);
        logic [511:0] v;
        for (int w = 0; w < 8; w++)
            v[w*64 +: 64] = 64'((s + 1) * 1000 + w) * 64'h9E37_79B9_7F4A_7C15;
        return v;
    endfunction

    task automatic report();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    logic [511:0] p1, p2, p1m;

    initial begin
        p1 = pat(1); p2 = pat(2);
        p1m = p1; p1m[3*64 +: 64] = ~p1m[3*64 +: 64];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(busy === 1'b0 && done === 1'b0, "R13", {510'd0, busy, done}, '0);
        chk(rdata === '0, "R13", rdata, '0);
        chk(result === '0, "R13", {448'd0, result}, '0);
        issue(0, 5, 0, 0, 0, '0);
        chk(rdata === '0, "R13", rdata, '0);

        // R1 writes and read-back
        issue(1, 0, 0, 0, 0, p1);
        issue(1, 0, 0, 1, 0, p2);
        issue(1, 0, 0, 2, 0, p1m);
        issue(1, 0, 0, 3, 0, p1);
        issue(1, 0, 0, 4, 0, {512{1'b1}});
        issue(1, 0, 0, 5, 0, '0);
        issue(1, 0, 0, 6, 0, pat(3));
        issue(1, 0, 0, 7, 0, pat(4));
        issue(0, 1, 0, 0, 0, '0);
        chk(rdata === p2, "R1", rdata, p2);

        // R8 compare: one differing word, all equal, none equal
        issue(8, 0, 2, 0, 0, '0);
        chk(result === 64'hF7, "R8", {448'd0, result}, 512'hF7);
        issue(8, 0, 3, 0, 0, '0);
        chk(result === 64'hFF, "R8", {448'd0, result}, 512'hFF);
        issue(8, 0, 1, 0, 0, '0);
        // R9 search with key row 0
        issue(9, 0, 0, 0, 0, '0);
        chk(result[7:0] === 8'hFF && result[23:16] === 8'hF7, "R9",
            {448'd0, result}, {448'd0, m_res});
        // R10 clmul at every granularity code
        for (int g = 0; g < 4; g++) issue(10, 0, 1, 0, g, '0);
        issue(10, 4, 4, 0, 0, '0);
        chk(result === 64'h0, "R10", {448'd0, result}, '0);

        // R2..R7 in-place row operations, each read back
        issue(4, 0, 1, 6, 0, '0); issue(0, 6, 0, 0, 0, '0);
        chk(rdata === (p1 & p2), "R2", rdata, p1 & p2);
        issue(5, 0, 1, 7, 0, '0); issue(0, 7, 0, 0, 0, '0);
        chk(rdata === (p1 | p2), "R3", rdata, p1 | p2);
        issue(6, 0, 4, 5, 0, '0); issue(0, 5, 0, 0, 0, '0);
        chk(rdata === ~p1, "R4", rdata, ~p1);
        issue(7, 1, 0, 2, 0, '0); issue(0, 2, 0, 0, 0, '0);
        chk(rdata === ~p2, "R5", rdata, ~p2);
        issue(2, 1, 0, 3, 0, '0); issue(0, 3, 0, 0, 0, '0);
        chk(rdata === p2, "R6", rdata, p2);
        issue(0, 1, 0, 0, 0, '0);
        chk(rdata === p2, "R6", rdata, p2);
        issue(3, 0, 0, 4, 0, {512{1'b1}}); issue(0, 4, 0, 0, 0, '0);
        chk(rdata === '0, "R7", rdata, '0);

        // R12: write attempts while busy with an AND are ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd4; cmd_ra = 3'd0; cmd_rb = 3'd0; cmd_rd = 3'd6;
        @(negedge clk);
        cmd_op = 4'd1; cmd_rd = 3'd0; cmd_wdata = pat(9);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        while (m_rem > 0) @(negedge clk);
        issue(0, 0, 0, 0, 0, '0);
        chk(rdata === p1, "R12", rdata, p1);
        // R12: unknown opcode ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd12; cmd_rd = 3'd0; cmd_wdata = pat(8);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b0, "R12", {511'd0, busy}, '0);
        issue(0, 0, 0, 0, 0, '0);
        chk(rdata === p1, "R12", rdata, p1);
        repeat (4) @(negedge clk);
        report();
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule